// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a peripheral clock into the bit-time structure of a CAN node. A prescaler divides the clock into time quanta. A sequencer then steps each bit through three segments: a one-quantum sync segment, segment 1 and segment 2. It raises a one-clock strobe at the sample point and another at the start of each bit. It also captures the bus level at the sample point.

When the bus input shows a recessive-to-dominant edge, the sequencer measures the phase error in whole quanta. An edge in segment 1 lengthens segment 1. An edge in segment 2 shortens segment 2. In both cases the change is clamped by a programmable jump width. An edge during the sync segment is treated as in phase, and nothing is adjusted.

All settings come from one packed 32-bit configuration word. Every timing field is coded as the wanted length minus one. The word also holds two debug bits: silent, which holds the bus output recessive, and loopback, which takes the sampled value from the node's own transmit signal. Both bits are passed on to the rest of the controller. The configuration word is treated as static while the bus is in use.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts (P+1) clock periods, where P is the prescaler field in `cfg_i[9:0]`.
- R2: With no bus edge, a bit lasts 1 + (A+1) + (B+1) quanta. A is the segment-1 field in `cfg_i[19:16]` and B is the segment-2 field in `cfg_i[22:20]`. `bit_start_o` pulses for one clock as each bit's sync segment begins.
- R3: `sample_o` pulses for one clock when segment 1 ends, which is (A+2) quanta after the bit start. `rx_bit_o` then holds the bus level seen at that point. Recessive is 1 and dominant is 0.
- R4: `sample_o` and `bit_start_o` are never high in the same cycle.
- R5: A falling bus edge in segment 1, during quantum c of that segment (counted from 0), lengthens segment 1 by min(c+1, J+1) quanta. J is the jump-width field in `cfg_i[25:24]`.
- R6: A falling bus edge in segment 2, during quantum c with r = B+1-c quanta left, shortens segment 2 by min(r, J+1). The segment never ends before the end of the current quantum.
- R7: A falling edge during the sync segment changes no segment length.
- R8: At most one resynchronization is applied per bit. Later edges in the same bit are ignored.
- R9: When `cfg_i[30]` (loopback) is 1, both sampling and edge detection use `tx_i`, and `rx_i` has no effect. `loopback_o` mirrors `cfg_i[30]`.
- R10: When `cfg_i[31]` (silent) is 1, `tx_o` is held at 1. Otherwise `tx_o` equals `tx_i`. `silent_o` mirrors `cfg_i[31]`.
- R11: Reserved bits 29:26, 23 and 15:10 of `cfg_i` have no effect on timing or outputs.
- R12: After reset, `sample_o` and `bit_start_o` are 0 and `rx_bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Packed timing and debug configuration |
| rx_i | input | 1 | Bus receive level (1 = recessive) |
| tx_i | input | 1 | Internal transmit level from the controller |
| tx_o | output | 1 | Bus transmit level |
| sample_o | output | 1 | Sample-point strobe |
| bit_start_o | output | 1 | Bit-start strobe |
| rx_bit_o | output | 1 | Bus value captured at the last sample point |
| silent_o | output | 1 | Silent debug mode flag |
| loopback_o | output | 1 | Loopback debug mode flag |

## Verification
The bench places single falling edges in the sync segment, early in segment 1 and early in segment 2. It uses two jump widths, so that in one case the clamp decides the correction and in the other the phase error does. A design that gets the clamp wrong, or that measures the error from the wrong quantum, moves the sample strobe or the next bit start by whole quanta, and the bench measures exactly those distances.

A second edge in an already corrected bit exposes a design that resynchronizes more than once per bit, because the bit comes out one quantum longer. Edges on the ignored input in loopback mode, together with reserved configuration bits set to 1, catch designs that decode the wrong source or the wrong bits: their bit period changes.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W = 10;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int SJW_W = 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;

  typedef struct packed {
    logic             silent;
    logic             loopback;
    logic [3:0]       rsv_hi;
    logic [SJW_W-1:0] sjw;
    logic             rsv_mid;
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [5:0]       rsv_lo;
    logic [BRP_W-1:0] brp;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tq_tick_o
);
  logic [BRP_W-1:0] cnt_q;

  // >= keeps the divider safe if the prescaler shrinks mid-count
  assign tq_tick_o = (cnt_q >= brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (tq_tick_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + BRP_W'(1);
  end

  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_tick_o && brp_i != '0 && $stable(brp_i)) |=> !tq_tick_o);
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tx_i,
  input  logic loopback_i,
  output logic bus_o,
  output logic fall_o
);
  logic             sel;
  logic [STAGES-1:0] sync_q;
  logic             prev_q;

  assign sel = loopback_i ? tx_i : rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= sel;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign bus_o = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= bus_o;
  end

  // recessive (1) to dominant (0)
  assign fall_o = prev_q & ~bus_o;

  a_r5_fall_needs_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_tick_i,
  input  logic             fall_i,
  input  logic             bus_i,
  input  logic [TS1_W-1:0] ts1_i,
  input  logic [TS2_W-1:0] ts2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             bit_start_o,
  output logic             rx_bit_o
);
  localparam int SEG_W = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int CNT_W = SEG_W + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(1 << SJW_W);

  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_q, ext_q, shr_q;
  logic             resynced_q, sample_q, bit_start_q, rx_bit_q;

  logic [CNT_W-1:0] seg1_len, seg2_len, lim, err1, rem2;
  logic [CNT_W-1:0] ext_new, shr_new, ext_eff, shr_eff;
  logic             adj_ok, end1, end2;

  always_comb begin
    seg1_len = CNT_W'(ts1_i) + ONE;
    seg2_len = CNT_W'(ts2_i) + ONE;
    lim      = CNT_W'(sjw_i) + ONE;
    adj_ok   = fall_i && !resynced_q && (seg_q != SEG_SYNC);
    err1     = cnt_q + ONE;
    rem2     = seg2_len - cnt_q;
    ext_new  = (err1 < lim) ? err1 : lim;
    shr_new  = (rem2 < lim) ? rem2 : lim;
    ext_eff  = (adj_ok && seg_q == SEG_ONE) ? ext_new : ext_q;
    shr_eff  = (adj_ok && seg_q == SEG_TWO) ? shr_new : shr_q;
    end1     = (cnt_q + ONE) >= (seg1_len + ext_eff);
    end2     = (cnt_q + ONE + shr_eff) >= seg2_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q       <= SEG_SYNC;
      cnt_q       <= '0;
      ext_q       <= '0;
      shr_q       <= '0;
      resynced_q  <= 1'b0;
      sample_q    <= 1'b0;
      bit_start_q <= 1'b0;
      rx_bit_q    <= 1'b1;
    end else begin
      sample_q    <= 1'b0;
      bit_start_q <= 1'b0;
      if (adj_ok) begin
        resynced_q <= 1'b1;
        ext_q      <= ext_eff;
        shr_q      <= shr_eff;
      end
      if (tq_tick_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_ONE;
            cnt_q <= '0;
          end
          SEG_ONE: begin
            if (end1) begin
              seg_q    <= SEG_TWO;
              cnt_q    <= '0;
              sample_q <= 1'b1;
              rx_bit_q <= bus_i;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          SEG_TWO: begin
            if (end2) begin
              seg_q       <= SEG_SYNC;
              cnt_q       <= '0;
              bit_start_q <= 1'b1;
              ext_q       <= '0;
              shr_q       <= '0;
              resynced_q  <= 1'b0;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          default: begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assign sample_o    = sample_q;
  assign bit_start_o = bit_start_q;
  assign rx_bit_o    = rx_bit_q;

  a_r4_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_q && bit_start_q));
  a_r3_sample_opens_seg2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |-> (seg_q == SEG_TWO && cnt_q == '0));
  a_r5_ext_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= LIM_MAX);
  a_r6_shr_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_q <= LIM_MAX);
  a_r7_sync_no_adjust: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_SYNC) |=> (ext_q == '0 && shr_q == '0));
  a_r8_single_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resynced_q && !(tq_tick_i && seg_q == SEG_TWO)) |=> ($stable(ext_q) && $stable(shr_q)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_i,
  input  logic        rx_i,
  input  logic        tx_i,
  output logic        tx_o,
  output logic        sample_o,
  output logic        bit_start_o,
  output logic        rx_bit_o,
  output logic        silent_o,
  output logic        loopback_o
);
  bt_cfg_t cfg;
  logic    tq_tick, bus, fall;

  assign cfg        = bt_cfg_t'(cfg_i);
  assign silent_o   = cfg.silent;
  assign loopback_o = cfg.loopback;
  assign tx_o       = cfg.silent ? 1'b1 : tx_i;

  can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .brp_i    (cfg.brp),
    .tq_tick_o(tq_tick)
  );

  can_bt_edge #(.STAGES(1)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .tx_i      (tx_i),
    .loopback_i(cfg.loopback),
    .bus_o     (bus),
    .fall_o    (fall)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tq_tick_i  (tq_tick),
    .fall_i     (fall),
    .bus_i      (bus),
    .ts1_i      (cfg.ts1),
    .ts2_i      (cfg.ts2),
    .sjw_i      (cfg.sjw),
    .sample_o   (sample_o),
    .bit_start_o(bit_start_o),
    .rx_bit_o   (rx_bit_o)
  );

  a_r10_silent_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.silent |-> tx_o);
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg_i;
  logic        rx_i = 1'b1;
  logic        tx_i = 1'b1;
  logic        tx_o, sample_o, bit_start_o, rx_bit_o, silent_o, loopback_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  can_bit_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .rx_i(rx_i), .tx_i(tx_i),
    .tx_o(tx_o), .sample_o(sample_o), .bit_start_o(bit_start_o),
    .rx_bit_o(rx_bit_o), .silent_o(silent_o), .loopback_o(loopback_o)
  );

  function automatic logic [31:0] mk_cfg(bit sil, bit lb, int sjw, int ts2, int ts1, int brp);
    return {sil, lb, 4'b0, 2'(sjw), 1'b0, 3'(ts2), 4'(ts1), 6'b0, 10'(brp)};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_bs();
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk_i);
      if (bit_start_o) return;
    end
    errors++;
    $display("FAIL sync: no bit start seen");
  endtask

  task automatic align(logic [31:0] c);
    @(negedge clk_i);
    cfg_i = c;
    wait_bs();
    wait_bs();
  endtask

  // k counts negedges after the observed bit start; -1 disables an event
  task automatic run_bit(bit use_tx, int f1, int r1, int f2, int r2,
                         output int per, output int samp);
    samp = -1;
    per  = -1;
    for (int k = 1; k < 2000; k++) begin
      @(negedge clk_i);
      if (k == f1 || k == f2) begin if (use_tx) tx_i = 1'b0; else rx_i = 1'b0; end
      if (k == r1 || k == r2) begin if (use_tx) tx_i = 1'b1; else rx_i = 1'b1; end
      if (sample_o && samp < 0) samp = k;
      if (bit_start_o) begin per = k; break; end
    end
  endtask

  task automatic t_reset();
    check("R12 sample_o", int'(sample_o), 0);
    check("R12 bit_start_o", int'(bit_start_o), 0);
    check("R12 rx_bit_o", int'(rx_bit_o), 1);
  endtask

  task automatic t_period();
    int p, s;
    align(mk_cfg(0, 0, 0, 2, 3, 1));
    run_bit(0, -1, -1, -1, -1, p, s);
    check("R1 bit period brp=1", p, 16);
    check("R3 sample position brp=1", s, 10);
    align(mk_cfg(0, 0, 0, 1, 5, 1));
    run_bit(0, -1, -1, -1, -1, p, s);
    check("R2 bit period ts1=5 ts2=1", p, 18);
    check("R3 sample position ts1=5", s, 14);
    align(mk_cfg(0, 0, 0, 2, 3, 3));
    run_bit(0, -1, -1, -1, -1, p, s);
    check("R1 bit period brp=3", p, 32);
    check("R3 sample position brp=3", s, 20);
  endtask

  task automatic t_strobes();
    int both = 0;
    align(mk_cfg(0, 0, 0, 2, 3, 0));
    for (int k = 0; k < 100; k++) begin
      @(negedge clk_i);
      if (sample_o && bit_start_o) both++;
    end
    check("R4 strobes overlap count", both, 0);
  endtask

  task automatic t_sync_edge();
    int p, s;
    align(mk_cfg(0, 0, 3, 2, 3, 3));
    run_bit(0, 1, -1, -1, -1, p, s);
    check("R7 sync edge period", p, 32);
    check("R3 rx_bit_o dominant", int'(rx_bit_o), 0);
    rx_i = 1'b1;
    run_bit(0, -1, -1, -1, -1, p, s);
    check("R3 rx_bit_o recessive", int'(rx_bit_o), 1);
  endtask

  task automatic t_seg1();
    int p, s;
    align(mk_cfg(0, 0, 0, 2, 3, 3));
    run_bit(0, 8, 10, -1, -1, p, s);
    check("R5 seg1 clamp sample", s, 24);
    check("R5 seg1 clamp period", p, 36);
    align(mk_cfg(0, 0, 3, 2, 3, 3));
    run_bit(0, 8, 10, -1, -1, p, s);
    check("R5 seg1 error sample", s, 28);
    check("R5 seg1 error period", p, 40);
  endtask

  task automatic t_seg2();
    int p, s;
    align(mk_cfg(0, 0, 0, 2, 3, 3));
    run_bit(0, 20, 22, -1, -1, p, s);
    check("R6 seg2 clamp period", p, 28);
    align(mk_cfg(0, 0, 1, 2, 3, 3));
    run_bit(0, 20, 22, -1, -1, p, s);
    check("R6 seg2 shorten 2", p, 24);
  endtask

  task automatic t_once();
    int p, s;
    align(mk_cfg(0, 0, 3, 2, 3, 3));
    run_bit(0, 8, 10, 13, 15, p, s);
    check("R8 second edge ignored", p, 40);
    run_bit(0, -1, -1, -1, -1, p, s);
    check("R8 next bit nominal", p, 32);
  endtask

  task automatic t_loopback();
    int p, s;
    align(mk_cfg(0, 1, 0, 2, 3, 3));
    check("R9 loopback_o", int'(loopback_o), 1);
    run_bit(0, 8, 10, -1, -1, p, s);
    check("R9 rx edge ignored", p, 32);
    check("R9 rx level ignored", int'(rx_bit_o), 1);
    run_bit(1, 8, 30, -1, -1, p, s);
    check("R9 tx edge resyncs", p, 36);
    check("R9 tx sampled", int'(rx_bit_o), 0);
    check("R10 tx_o follows tx_i", int'(tx_o), 1);
  endtask

  task automatic t_silent();
    @(negedge clk_i);
    cfg_i = mk_cfg(1, 0, 0, 2, 3, 3);
    tx_i = 1'b0;
    @(negedge clk_i);
    check("R10 silent tx_o", int'(tx_o), 1);
    check("R10 silent_o", int'(silent_o), 1);
    cfg_i = mk_cfg(0, 0, 0, 2, 3, 3);
    @(negedge clk_i);
    check("R10 normal tx_o", int'(tx_o), 0);
    check("R10 silent_o off", int'(silent_o), 0);
    tx_i = 1'b1;
  endtask

  task automatic t_reserved();
    int p, s;
    align(mk_cfg(0, 0, 0, 2, 3, 3) | 32'h3C80_FC00);
    run_bit(0, -1, -1, -1, -1, p, s);
    check("R11 reserved period", p, 32);
    check("R11 reserved sample", s, 20);
    check("R11 reserved silent_o", int'(silent_o), 0);
    check("R11 reserved loopback_o", int'(loopback_o), 0);
  endtask

  initial begin
    cfg_i = mk_cfg(0, 0, 0, 2, 3, 3);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_period();
    t_strobes();
    t_sync_edge();
    t_seg1();
    t_seg2();
    t_once();
    t_loopback();
    t_silent();
    t_reserved();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule